// File: doc/BRIEF.md
# MII Management Interrupt Status Register

This block gathers the interrupt causes of an MII management engine into one host-visible register. There are three causes. The first is the end of a management access that the host started through the data port. The second is the end of a management frame that the engine generated on its own, for example from an auto-poll sequencer. The third is a mismatch reported by an auto-poll comparison. Each cause has a sticky status flag and a separate enable bit. A single registered interrupt output is raised while any flag is set together with its own enable.

The management engine reports each cause with a one-cycle strobe input. The host reads the register at any time. It writes the register through a select and write-enable pair. Writing 1 to a flag clears it. The enable bits are ordinary read/write bits.

Only the hard reset input clears the register. The soft-reset and stop inputs reach the block but leave every bit as it is. The register port is a plain select/write-enable port with a combinational read. It has no valid/ready handshake and no back-pressure: a write is taken in the cycle it is presented, and the event strobes cannot be stalled.

Top module: `mgmt_irq_status`

## Requirements
- R1: While `hard_rst_n` is low, every flag and enable reads 0 and `irq` is 0.
- R2: The register layout is as follows, and all other bits of `reg_rdata` read 0.

  | Bit | Content |
  |-----|---------|
  | 7 | poll-mismatch flag |
  | 6 | poll-mismatch enable |
  | 5 | host-completion flag |
  | 4 | host-completion enable |
  | 3 | internal-completion flag |
  | 2 | internal-completion enable |
- R3: A strobe sets its own flag only, and the new value is visible at the next clock edge. `ev_host_done` sets bit 5, `ev_int_done` sets bit 3 and `ev_poll_mismatch` sets bit 7. Internally generated completions never set bit 5.
- R4: A register write with 1 in a flag position clears that flag. A 0 in a flag position leaves the flag unchanged.
- R5: When a strobe and a write-1-to-clear hit the same flag in the same cycle, the flag ends up set.
- R6: A register write loads bits 6, 4 and 2 of `reg_wdata` into the three enables.
- R7: `soft_rst` and `stop` change no flag, no enable and no output.
- R8: `irq` is registered. After each clock edge it equals the OR, taken before that edge, of each flag ANDed with its own enable.
- R9: A register write takes effect only when `reg_sel` and `reg_wr_en` are both 1. With either one at 0, the register is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| hard_rst_n | input | 1 | Asynchronous active-low hard reset; clears all bits |
| soft_rst | input | 1 | Soft reset request; has no effect on this register |
| stop | input | 1 | Stop control; has no effect on this register |
| reg_sel | input | 1 | Register select |
| reg_wr_en | input | 1 | Write enable |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Current register contents |
| ev_host_done | input | 1 | Strobe: host-initiated management access finished |
| ev_int_done | input | 1 | Strobe: internally generated management frame finished |
| ev_poll_mismatch | input | 1 | Strobe: auto-poll comparison mismatch |
| irq | output | 1 | Combined registered interrupt |

## Verification
The bench builds the block with the default `DATA_W` of 8. This is the narrowest width that holds the fixed bit layout, so every bit of the read data, including the always-zero bits 1 and 0, is compared exactly. The vector table walks each flag through set, hold and clear, each enable through load and drop, and the one-cycle lag of `irq` behind the flag and enable state. Directed steps then cover set-versus-clear collisions, soft reset and stop while an interrupt is pending, and a hard reset that lands with all bits set.

// File: rtl/mgmt_irq_pkg.sv
package mgmt_irq_pkg;
  localparam int NUM_SRC  = 3;
  localparam int MIN_DATA = 8;

  typedef enum int {
    SRC_HOST = 0,
    SRC_INTL = 1,
    SRC_POLL = 2
  } irq_src_e;

  function automatic int flag_pos(input int src);
    case (src)
      SRC_HOST: flag_pos = 5;
      SRC_INTL: flag_pos = 3;
      default:  flag_pos = 7;
    endcase
  endfunction

  function automatic int en_pos(input int src);
    en_pos = flag_pos(src) - 1;
  endfunction
endpackage

// File: rtl/irq_flag_cell.sv
module irq_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o);
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(flag_o));
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] en_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    en_o <= '0;
    else if (wr_i) en_o <= d_i;
  end

  p_en_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (en_o == $past(d_i)));
  p_en_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(en_o));
endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] flag_i,
  input  logic [N-1:0] en_i,
  output logic         irq_o
);
  logic pend;
  assign pend = |(flag_i & en_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= pend;
  end

  p_irq_lag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(|(flag_i & en_i)));
  p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flag_i & en_i)) |=> irq_o);
endmodule

// File: rtl/mgmt_irq_status.sv
module mgmt_irq_status
  import mgmt_irq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              hard_rst_n,
  input  logic              soft_rst,
  input  logic              stop,
  input  logic              reg_sel,
  input  logic              reg_wr_en,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              ev_host_done,
  input  logic              ev_int_done,
  input  logic              ev_poll_mismatch,
  output logic              irq
);
  localparam int N = NUM_SRC;

  if (DATA_W < MIN_DATA) begin : g_width_check
    $error("DATA_W too small for register layout");
  end

  logic         wr_hit;
  logic [N-1:0] ev;
  logic [N-1:0] flag;
  logic [N-1:0] en;
  logic [N-1:0] en_d;
  logic         unused_inputs;

  assign wr_hit        = reg_sel & reg_wr_en;
  assign ev[SRC_HOST]  = ev_host_done;
  assign ev[SRC_INTL]  = ev_int_done;
  assign ev[SRC_POLL]  = ev_poll_mismatch;
  assign unused_inputs = ^{reg_wdata, soft_rst, stop};

  for (genvar i = 0; i < N; i++) begin : g_src
    irq_flag_cell u_flag (
      .clk    (clk),
      .rst_n  (hard_rst_n),
      .set_i  (ev[i]),
      .clr_i  (wr_hit & reg_wdata[flag_pos(i)]),
      .flag_o (flag[i])
    );
    assign en_d[i] = reg_wdata[en_pos(i)];
  end

  irq_enable_reg #(.N(N)) u_en (
    .clk   (clk),
    .rst_n (hard_rst_n),
    .wr_i  (wr_hit),
    .d_i   (en_d),
    .en_o  (en)
  );

  irq_combine #(.N(N)) u_comb (
    .clk    (clk),
    .rst_n  (hard_rst_n),
    .flag_i (flag),
    .en_i   (en),
    .irq_o  (irq)
  );

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < N; i++) begin
      reg_rdata[flag_pos(i)] = flag[i];
      reg_rdata[en_pos(i)]   = en[i];
    end
  end

  // R7: soft reset and stop do not disturb the register
  p_quiet_r7: assert property (@(posedge clk) disable iff (!hard_rst_n)
    ((soft_rst || stop) && !wr_hit && ev == '0) |=> $stable(reg_rdata));
  // R3: internal completion alone never raises the host flag
  p_host_only_r3: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (!ev_host_done && !reg_rdata[5]) |=> !reg_rdata[5]);
  // R2: unused bits stay zero
  p_spare_zero_r2: assert property (@(posedge clk) disable iff (!hard_rst_n)
    reg_rdata[1:0] == 2'b00);
endmodule

// File: tb/sim_mgmt_irq_status.sv
module sim_mgmt_irq_status;
  logic       clk = 1'b0;
  logic       hard_rst_n = 1'b0;
  logic       soft_rst = 1'b0, stop = 1'b0;
  logic       reg_sel = 1'b0, reg_wr_en = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       ev_host_done = 1'b0, ev_int_done = 1'b0, ev_poll_mismatch = 1'b0;
  logic       irq;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #2 clk = ~clk;

  mgmt_irq_status #(.DATA_W(8)) u0 (
    .clk, .hard_rst_n, .soft_rst, .stop, .reg_sel, .reg_wr_en,
    .reg_wdata, .reg_rdata, .ev_host_done, .ev_int_done,
    .ev_poll_mismatch, .irq
  );

  // {sel, we, wdata[8], host,intl,poll[3], soft,stop[2], exp_rdata[8], exp_irq}
  localparam int NV = 21;
  localparam logic [23:0] VECS [NV] = '{
    {2'b11, 8'h54, 3'b000, 2'b00, 8'h54, 1'b0}, // R6 load enables
    {2'b00, 8'h00, 3'b100, 2'b00, 8'h74, 1'b0}, // R3 host flag
    {2'b00, 8'h00, 3'b000, 2'b00, 8'h74, 1'b1}, // R8 lagged irq
    {2'b11, 8'h74, 3'b000, 2'b00, 8'h54, 1'b1}, // R4 clear bit 5
    {2'b00, 8'h00, 3'b000, 2'b00, 8'h54, 1'b0}, // R8
    {2'b00, 8'h00, 3'b010, 2'b00, 8'h5C, 1'b0}, // R3 internal flag only
    {2'b00, 8'h00, 3'b001, 2'b00, 8'hDC, 1'b1}, // R3 poll flag
    {2'b11, 8'h00, 3'b000, 2'b00, 8'h88, 1'b1}, // R4 zeros keep flags, R6
    {2'b00, 8'h00, 3'b000, 2'b00, 8'h88, 1'b0}, // R8
    {2'b10, 8'hFF, 3'b000, 2'b00, 8'h88, 1'b0}, // R9 no write enable
    {2'b01, 8'hFF, 3'b000, 2'b00, 8'h88, 1'b0}, // R9 no select
    {2'b00, 8'h00, 3'b000, 2'b11, 8'h88, 1'b0}, // R7
    {2'b11, 8'hC0, 3'b000, 2'b00, 8'h48, 1'b0}, // R4 clear bit 7
    {2'b11, 8'h0C, 3'b010, 2'b00, 8'h0C, 1'b0}, // R5 set wins
    {2'b00, 8'h00, 3'b000, 2'b00, 8'h0C, 1'b1}, // R8
    {2'b11, 8'h08, 3'b100, 2'b00, 8'h20, 1'b1}, // R4 + R3
    {2'b00, 8'h00, 3'b000, 2'b00, 8'h20, 1'b0}, // R8
    {2'b11, 8'h10, 3'b000, 2'b00, 8'h30, 1'b0}, // R6
    {2'b00, 8'h00, 3'b000, 2'b00, 8'h30, 1'b1}, // R8
    {2'b11, 8'h20, 3'b000, 2'b00, 8'h00, 1'b1}, // R4
    {2'b00, 8'h00, 3'b000, 2'b00, 8'h00, 1'b0}  // R2 all zero
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic drive(input logic s, input logic w, input logic [7:0] d,
                       input logic [2:0] e, input logic [1:0] q);
    reg_sel = s; reg_wr_en = w; reg_wdata = d;
    {ev_host_done, ev_int_done, ev_poll_mismatch} = e;
    {soft_rst, stop} = q;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below 5000 cycles", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset rdata", reg_rdata, 8'h00);
    chk("R1 reset irq", {7'd0, irq}, 8'h00);
    hard_rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      drive(VECS[k][23], VECS[k][22], VECS[k][21:14], VECS[k][13:11], VECS[k][10:9]);
      chk($sformatf("R2/R8 vector %0d rdata", k), reg_rdata, VECS[k][8:1]);
      chk($sformatf("R8 vector %0d irq", k), {7'd0, irq}, {7'd0, VECS[k][0]});
    end

    // Directed: all sources at once, then soft reset / stop while pending
    drive(1'b1, 1'b1, 8'h54, 3'b000, 2'b00);
    drive(1'b0, 1'b0, 8'h00, 3'b111, 2'b00);
    chk("R3 all flags", reg_rdata, 8'hFC);
    drive(1'b0, 1'b0, 8'h00, 3'b000, 2'b00);
    chk("R8 irq pending", {7'd0, irq}, 8'h01);
    for (int k = 0; k < 3; k++) begin
      drive(1'b0, 1'b0, 8'h00, 3'b000, 2'b11);
      chk("R7 soft/stop rdata", reg_rdata, 8'hFC);
      chk("R7 soft/stop irq", {7'd0, irq}, 8'h01);
    end
    // Collision on every flag at once
    drive(1'b1, 1'b1, 8'hA8, 3'b111, 2'b00);
    chk("R5 collision all", reg_rdata, 8'hA8);
    drive(1'b0, 1'b0, 8'h00, 3'b000, 2'b00);
    chk("R6 enables cleared irq low", {7'd0, irq}, 8'h00);
    drive(1'b1, 1'b1, 8'hFC, 3'b000, 2'b00);
    chk("R4 clear all flags, R6 enables", reg_rdata, 8'h54);
    drive(1'b0, 1'b0, 8'h00, 3'b111, 2'b00);
    // Hard reset with all bits set
    hard_rst_n = 1'b0;
    #1;
    chk("R1 hard reset rdata", reg_rdata, 8'h00);
    chk("R1 hard reset irq", {7'd0, irq}, 8'h00);
    drive(1'b0, 1'b0, 8'h00, 3'b000, 2'b00);
    hard_rst_n = 1'b1;
    drive(1'b0, 1'b0, 8'h00, 3'b000, 2'b00);
    chk("R1 after release", reg_rdata, 8'h00);
    finish_run();
  end
endmodule